// File: doc/BRIEF.md
# Speculative Retirement Buffer

This block holds the results of instructions that have issued but not yet retired. Each accepted issue takes the entry at the tail of a circular buffer, and that entry's number goes back to the issuing logic as the destination tag. Execution units report results on a shared result bus by tag. The buffer stores the result in the matching entry, in any order. Retirement always happens at the head, one entry per cycle and in program order. A retiring entry either writes the register file, performs a store, or, for a branch, does nothing.

A per-register table records which in-flight entry is the youngest writer of each architectural register. Issue logic reads this table through the lookup ports. Each lookup returns whether the register is pending, the tag of its producer, and, once that producer has finished, its value. When a mispredicted branch or a faulting instruction reaches the head, no architectural state changes. Every entry and every table mapping is discarded, and the block raises a one-cycle redirect.

Top module: `spec_retire_buffer`

## Requirements
- R1: After a synchronous active-low reset, `empty` is 1 and `full` is 0, and `rf_we`, `st_we` and `redirect` are all 0.
- R2: The buffer holds DEPTH entries (8 by default). `full` is 1 exactly while DEPTH entries are held, and no further issue is accepted then.
- R3: `iss_ok` equals `iss_valid` AND `iss_rs_free` AND NOT `full` AND NOT `redirect`. `iss_tag` is the tail entry number. Tags count 0, 1, … modulo DEPTH, starting at 0 after reset or a flush.
- R4: A bus beat (`cdb_valid`) whose tag names an occupied entry stores the value and both flags in that entry and marks it ready.
- R5: Lookup port i reports `lk_busy` for a register that an in-flight entry will write, the tag of the youngest such entry in `lk_tag`, `lk_ready` once that entry holds its result, and the result in `lk_value`.
- R6: Only the head entry retires, and only when it was already ready at the start of the cycle. A result captured in cycle n retires in cycle n+1 at the earliest. At most one entry retires per cycle.
- R7: At retirement a register mapping is cleared only if it still names the retiring entry. A younger writer keeps the register pending.
- R8: Kind encoding is 0 = register write, 1 = store, 2 = branch. A retiring kind 0 entry drives `rf_we` with `rf_idx` equal to the low RIDX_W bits of its destination and `rf_data` equal to its result. A kind 1 entry drives `st_we` with `st_addr` equal to its destination and `st_data` equal to its result. `rf_we` and `st_we` are never both 1.
- R9: A kind 2 entry at the head that is ready with `cdb_misp` set raises `redirect` for one cycle and writes nothing. It empties the buffer and the register table, so the next tag is 0.
- R10: A ready head entry whose `cdb_exc` was set behaves as in R9, whatever its kind.
- R11: A ready branch entry without the mispredict flag retires with no write and no redirect.
- R12: A bus beat whose tag names an unoccupied entry is ignored. A later issue into that entry starts not ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | An instruction requests an entry |
| iss_rs_free | input | 1 | A reservation station is free for it |
| iss_kind | input | 2 | 0 register write, 1 store, 2 branch |
| iss_dest | input | ADDR_W | Register number (low bits) or store address |
| iss_ok | output | 1 | Issue accepted this cycle |
| iss_tag | output | TAG_W | Entry number allocated |
| full | output | 1 | All entries occupied |
| empty | output | 1 | No entry occupied |
| lk_reg | input | NSRC x RIDX_W | Registers looked up |
| lk_busy | output | NSRC | Register has an in-flight writer |
| lk_tag | output | NSRC x TAG_W | Youngest writer's entry |
| lk_ready | output | NSRC | That writer holds its result |
| lk_value | output | NSRC x XLEN | That result |
| cdb_valid | input | 1 | Result bus beat |
| cdb_tag | input | TAG_W | Entry the result belongs to |
| cdb_value | input | XLEN | Result value |
| cdb_exc | input | 1 | Instruction faulted |
| cdb_misp | input | 1 | Branch was mispredicted |
| rf_we | output | 1 | Register file write at retirement |
| rf_idx | output | RIDX_W | Register written |
| rf_data | output | XLEN | Data written |
| st_we | output | 1 | Store performed at retirement |
| st_addr | output | ADDR_W | Store address |
| st_data | output | XLEN | Store data |
| redirect | output | 1 | Flush pulse, fetch must restart |

## Verification
`iss_ok`, `iss_tag` and the lookup outputs are combinational. The bench reads them one time step after it drives the inputs, in the same half cycle. A bus beat changes the entry at the next rising edge, so the retirement outputs and the redirect for a head entry are sampled at the falling edge that follows that edge, and not before. The popping, and the emptying after a flush, is then checked one further edge later. Every value the bench expects comes from the tag arithmetic (allocation order modulo DEPTH) and from values of the form base plus tag.

// File: rtl/srb_pkg.sv
// Shared definitions for the speculative retirement buffer.
// Assumes: two-bit kind field on the issue port; encoding 3 is unused.
package srb_pkg;
    typedef enum logic [1:0] {
        KIND_REG    = 2'd0,
        KIND_STORE  = 2'd1,
        KIND_BRANCH = 2'd2
    } srb_kind_e;
endpackage

// File: rtl/srb_ptrs.sv
// Head/tail pointers and occupancy count of the circular buffer.
// Assumes: the caller never pushes when full nor pops when empty;
// clear returns both pointers to entry 0.
module srb_ptrs #(
    parameter int DEPTH = 8,
    parameter int TAG_W = $clog2(DEPTH),
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             clear,
    output logic [TAG_W-1:0] head,
    output logic [TAG_W-1:0] tail,
    output logic             full,
    output logic             empty
);
    localparam logic [TAG_W-1:0] LAST = TAG_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);

    logic [CNT_W-1:0] count;

    // Next index with wrap at DEPTH.
    function automatic logic [TAG_W-1:0] bump(input logic [TAG_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    // Pointer and count update.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (push) tail <= bump(tail);
            if (pop)  head <= bump(head);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Occupancy flags.
    always_comb begin
        full  = (count == CAP);
        empty = (count == '0);
    end

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CAP);
    assert_pop_shrinks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !clear) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/srb_slots.sv
// Entry storage: kind, destination, result and flags per entry.
// Assumes: alloc_idx names a free entry; a capture is accepted only by
// an entry that is already occupied at the start of the cycle.
module srb_slots
    import srb_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int TAG_W  = $clog2(DEPTH),
    parameter int XLEN   = 32,
    parameter int ADDR_W = 16,
    parameter int NSRC   = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       alloc_en,
    input  logic [TAG_W-1:0]           alloc_idx,
    input  srb_kind_e                  alloc_kind,
    input  logic [ADDR_W-1:0]          alloc_dest,
    input  logic                       cap_en,
    input  logic [TAG_W-1:0]           cap_idx,
    input  logic [XLEN-1:0]            cap_value,
    input  logic                       cap_exc,
    input  logic                       cap_misp,
    input  logic                       free_en,
    input  logic [TAG_W-1:0]           head_idx,
    output logic                       hd_valid,
    output logic                       hd_ready,
    output srb_kind_e                  hd_kind,
    output logic [ADDR_W-1:0]          hd_dest,
    output logic [XLEN-1:0]            hd_value,
    output logic                       hd_exc,
    output logic                       hd_misp,
    input  logic [NSRC-1:0][TAG_W-1:0] rd_idx,
    output logic [NSRC-1:0]            rd_ready,
    output logic [NSRC-1:0][XLEN-1:0]  rd_value
);
    logic [DEPTH-1:0]             vld;
    logic [DEPTH-1:0]             rdy;
    logic [DEPTH-1:0]             exc;
    logic [DEPTH-1:0]             misp;
    srb_kind_e                    kind [DEPTH];
    logic [DEPTH-1:0][ADDR_W-1:0] dest;
    logic [DEPTH-1:0][XLEN-1:0]   val;

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        localparam logic [TAG_W-1:0] ME = TAG_W'(e);
        logic take_alloc, take_cap, take_free;
        assign take_alloc = alloc_en && (alloc_idx == ME);
        assign take_cap   = cap_en && (cap_idx == ME) && vld[e];
        assign take_free  = free_en && (head_idx == ME);

        // Occupancy and result state of one entry.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                vld[e]  <= 1'b0;
                rdy[e]  <= 1'b0;
                exc[e]  <= 1'b0;
                misp[e] <= 1'b0;
                kind[e] <= KIND_REG;
                dest[e] <= '0;
                val[e]  <= '0;
            end else if (take_alloc) begin
                vld[e]  <= 1'b1;
                rdy[e]  <= 1'b0;
                exc[e]  <= 1'b0;
                misp[e] <= 1'b0;
                kind[e] <= alloc_kind;
                dest[e] <= alloc_dest;
            end else if (take_free) begin
                vld[e] <= 1'b0;
                rdy[e] <= 1'b0;
            end else if (take_cap) begin
                rdy[e]  <= 1'b1;
                val[e]  <= cap_value;
                exc[e]  <= cap_exc;
                misp[e] <= cap_misp;
            end
        end
    end

    // Head entry view for retirement.
    always_comb begin
        hd_valid = vld[head_idx];
        hd_ready = rdy[head_idx];
        hd_kind  = kind[head_idx];
        hd_dest  = dest[head_idx];
        hd_value = val[head_idx];
        hd_exc   = exc[head_idx];
        hd_misp  = misp[head_idx];
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_read
        // Operand read of an in-flight entry.
        always_comb begin
            rd_ready[s] = vld[rd_idx[s]] && rdy[rd_idx[s]];
            rd_value[s] = val[rd_idx[s]];
        end
    end

    assert_alloc_free_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> !vld[alloc_idx]);
    assert_ready_needs_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && !vld[cap_idx] && !clear) |=> !rdy[$past(cap_idx)]);
endmodule

// File: rtl/srb_rename.sv
// Register status table: youngest in-flight writer per register.
// Assumes: a set in the same cycle as a matching clear wins; clear_all
// empties the table in one cycle.
module srb_rename #(
    parameter int NREG   = 16,
    parameter int RIDX_W = $clog2(NREG),
    parameter int TAG_W  = 3,
    parameter int NSRC   = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clear_all,
    input  logic                        set_en,
    input  logic [RIDX_W-1:0]           set_reg,
    input  logic [TAG_W-1:0]            set_tag,
    input  logic                        clr_en,
    input  logic [RIDX_W-1:0]           clr_reg,
    input  logic [TAG_W-1:0]            clr_tag,
    input  logic [NSRC-1:0][RIDX_W-1:0] q_reg,
    output logic [NSRC-1:0]             q_busy,
    output logic [NSRC-1:0][TAG_W-1:0]  q_tag
);
    logic [NREG-1:0]            map_vld;
    logic [NREG-1:0][TAG_W-1:0] map_tag;

    // Mapping update: conditional release, then fresh claim.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_all) begin
            map_vld <= '0;
            map_tag <= '0;
        end else begin
            if (clr_en && map_vld[clr_reg] && (map_tag[clr_reg] == clr_tag))
                map_vld[clr_reg] <= 1'b0;
            if (set_en) begin
                map_vld[set_reg] <= 1'b1;
                map_tag[set_reg] <= set_tag;
            end
        end
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_query
        // Lookup of one source register.
        always_comb begin
            q_busy[s] = map_vld[q_reg[s]];
            q_tag[s]  = map_tag[q_reg[s]];
        end
    end

    assert_keep_younger_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && map_vld[clr_reg] && (map_tag[clr_reg] != clr_tag) && !clear_all)
        |=> map_vld[$past(clr_reg)]);
endmodule

// File: rtl/spec_retire_buffer.sv
// Top: allocation at the tail, result capture by tag, in-order
// retirement at the head, flush on mispredict or fault.
// Assumes: one issue, one bus beat and one retirement per cycle at most;
// the issuing instruction's own lookups see the table before its claim.
module spec_retire_buffer
    import srb_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int XLEN   = 32,
    parameter int NREG   = 16,
    parameter int ADDR_W = 16,
    parameter int NSRC   = 2,
    parameter int TAG_W  = $clog2(DEPTH),
    parameter int RIDX_W = $clog2(NREG)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        iss_valid,
    input  logic                        iss_rs_free,
    input  logic [1:0]                  iss_kind,
    input  logic [ADDR_W-1:0]           iss_dest,
    output logic                        iss_ok,
    output logic [TAG_W-1:0]            iss_tag,
    output logic                        full,
    output logic                        empty,
    input  logic [NSRC-1:0][RIDX_W-1:0] lk_reg,
    output logic [NSRC-1:0]             lk_busy,
    output logic [NSRC-1:0][TAG_W-1:0]  lk_tag,
    output logic [NSRC-1:0]             lk_ready,
    output logic [NSRC-1:0][XLEN-1:0]   lk_value,
    input  logic                        cdb_valid,
    input  logic [TAG_W-1:0]            cdb_tag,
    input  logic [XLEN-1:0]             cdb_value,
    input  logic                        cdb_exc,
    input  logic                        cdb_misp,
    output logic                        rf_we,
    output logic [RIDX_W-1:0]           rf_idx,
    output logic [XLEN-1:0]             rf_data,
    output logic                        st_we,
    output logic [ADDR_W-1:0]           st_addr,
    output logic [XLEN-1:0]             st_data,
    output logic                        redirect
);
    logic [TAG_W-1:0]  head, tail;
    logic              hd_valid, hd_ready, hd_exc, hd_misp;
    srb_kind_e         hd_kind, in_kind;
    logic [ADDR_W-1:0] hd_dest;
    logic [XLEN-1:0]   hd_value;
    logic              retire, flush, pop;

    // Retirement decision for the head entry.
    always_comb begin
        in_kind  = srb_kind_e'(iss_kind);
        retire   = hd_valid && hd_ready;
        flush    = retire && (hd_exc || ((hd_kind == KIND_BRANCH) && hd_misp));
        pop      = retire && !flush;
        redirect = flush;
        iss_ok   = iss_valid && iss_rs_free && !full && !flush;
        iss_tag  = tail;
        rf_we    = pop && (hd_kind == KIND_REG);
        rf_idx   = hd_dest[RIDX_W-1:0];
        rf_data  = hd_value;
        st_we    = pop && (hd_kind == KIND_STORE);
        st_addr  = hd_dest;
        st_data  = hd_value;
    end

    srb_ptrs #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_ptrs (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (iss_ok),
        .pop   (pop),
        .clear (flush),
        .head  (head),
        .tail  (tail),
        .full  (full),
        .empty (empty)
    );

    srb_slots #(.DEPTH(DEPTH), .TAG_W(TAG_W), .XLEN(XLEN),
                .ADDR_W(ADDR_W), .NSRC(NSRC)) u_slots (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (flush),
        .alloc_en   (iss_ok),
        .alloc_idx  (tail),
        .alloc_kind (in_kind),
        .alloc_dest (iss_dest),
        .cap_en     (cdb_valid),
        .cap_idx    (cdb_tag),
        .cap_value  (cdb_value),
        .cap_exc    (cdb_exc),
        .cap_misp   (cdb_misp),
        .free_en    (pop),
        .head_idx   (head),
        .hd_valid   (hd_valid),
        .hd_ready   (hd_ready),
        .hd_kind    (hd_kind),
        .hd_dest    (hd_dest),
        .hd_value   (hd_value),
        .hd_exc     (hd_exc),
        .hd_misp    (hd_misp),
        .rd_idx     (lk_tag),
        .rd_ready   (lk_ready),
        .rd_value   (lk_value)
    );

    srb_rename #(.NREG(NREG), .RIDX_W(RIDX_W), .TAG_W(TAG_W),
                 .NSRC(NSRC)) u_rename (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_all (flush),
        .set_en    (iss_ok && (in_kind == KIND_REG)),
        .set_reg   (iss_dest[RIDX_W-1:0]),
        .set_tag   (tail),
        .clr_en    (rf_we),
        .clr_reg   (hd_dest[RIDX_W-1:0]),
        .clr_tag   (head),
        .q_reg     (lk_reg),
        .q_busy    (lk_busy),
        .q_tag     (lk_tag)
    );

    assert_single_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rf_we && st_we));
    assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> (empty && !redirect));
    assert_no_issue_on_flush_R3: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> !iss_ok);
    assert_issue_occupies_R2: assert property (@(posedge clk) disable iff (!rst_n)
        iss_ok |=> !empty);
    assert_quiet_when_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !(rf_we || st_we || redirect));
endmodule

// File: tb/spec_retire_buffer_tb.sv
module spec_retire_buffer_tb;
    localparam int DEPTH = 8, XLEN = 32, NREG = 16, ADDR_W = 16, NSRC = 2;
    localparam int TAG_W = 3, RIDX_W = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic iss_valid = 0, iss_rs_free = 1;
    logic [1:0] iss_kind = 0;
    logic [ADDR_W-1:0] iss_dest = 0;
    logic iss_ok, full, empty;
    logic [TAG_W-1:0] iss_tag;
    logic [NSRC-1:0][RIDX_W-1:0] lk_reg = '0;
    logic [NSRC-1:0] lk_busy, lk_ready;
    logic [NSRC-1:0][TAG_W-1:0] lk_tag;
    logic [NSRC-1:0][XLEN-1:0] lk_value;
    logic cdb_valid = 0, cdb_exc = 0, cdb_misp = 0;
    logic [TAG_W-1:0] cdb_tag = 0;
    logic [XLEN-1:0] cdb_value = 0;
    logic rf_we, st_we, redirect;
    logic [RIDX_W-1:0] rf_idx;
    logic [XLEN-1:0] rf_data, st_data;
    logic [ADDR_W-1:0] st_addr;

    int nchk = 0, nfail = 0;

    always #2.5 clk = ~clk;

    spec_retire_buffer u_dut (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_rs_free(iss_rs_free),
        .iss_kind(iss_kind), .iss_dest(iss_dest), .iss_ok(iss_ok), .iss_tag(iss_tag),
        .full(full), .empty(empty), .lk_reg(lk_reg), .lk_busy(lk_busy),
        .lk_tag(lk_tag), .lk_ready(lk_ready), .lk_value(lk_value),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
        .cdb_exc(cdb_exc), .cdb_misp(cdb_misp), .rf_we(rf_we), .rf_idx(rf_idx),
        .rf_data(rf_data), .st_we(st_we), .st_addr(st_addr), .st_data(st_data),
        .redirect(redirect)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Issue one instruction, checking acceptance and tag in the same cycle.
    task automatic issue(input logic [1:0] k, input logic [ADDR_W-1:0] d,
                         input logic ok, input logic [TAG_W-1:0] tg, input string req);
        iss_valid = 1; iss_kind = k; iss_dest = d;
        #1;
        chk({req, " iss_ok"}, 32'(iss_ok), 32'(ok));
        if (ok) chk({req, " iss_tag"}, 32'(iss_tag), 32'(tg));
        step();
        iss_valid = 0;
    endtask

    task automatic beat(input logic [TAG_W-1:0] tg, input logic [XLEN-1:0] v,
                        input logic e, input logic m);
        cdb_valid = 1; cdb_tag = tg; cdb_value = v; cdb_exc = e; cdb_misp = m;
        #1;
        chk("R6 no retire in capture cycle", 32'(rf_we | st_we | redirect), 32'(0));
        step();
        cdb_valid = 0; cdb_exc = 0; cdb_misp = 0;
    endtask

    task automatic look(input logic [RIDX_W-1:0] r0, input logic [RIDX_W-1:0] r1);
        lk_reg[0] = r0; lk_reg[1] = r1;
        #1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        chk("R1 empty", 32'(empty), 1);
        chk("R1 full", 32'(full), 0);
        chk("R1 quiet", 32'({rf_we, st_we, redirect}), 0);

        // R2/R3 fill with register writes r1..r8, tags 0..7
        for (int i = 0; i < DEPTH; i++)
            issue(2'd0, ADDR_W'(i + 1), 1'b1, TAG_W'(i), "R3");
        chk("R2 full", 32'(full), 1);
        issue(2'd0, 16'd9, 1'b0, '0, "R2 full blocks");

        // R5 pending lookup before results exist
        look(4'd3, 4'd8);
        chk("R5 busy", 32'(lk_busy[0]), 1);
        chk("R5 tag", 32'(lk_tag[0]), 2);
        chk("R5 not ready", 32'(lk_ready[0]), 0);
        chk("R5 port1 tag", 32'(lk_tag[1]), 7);

        // R4/R6 results arrive in reverse order, head stays blocked
        for (int t = DEPTH - 1; t >= 1; t--) begin
            beat(TAG_W'(t), 32'(100 + t), 1'b0, 1'b0);
            chk("R6 head not ready", 32'(rf_we), 0);
        end
        look(4'd5, 4'd3);
        chk("R4 ready", 32'(lk_ready[0]), 1);
        chk("R5 value", lk_value[0], 104);
        chk("R5 port1 value", lk_value[1], 102);

        // R6/R8 head result arrives, then one retirement per cycle
        beat('0, 32'd100, 1'b0, 1'b0);
        for (int k = 0; k < DEPTH; k++) begin
            chk("R8 rf_we", 32'(rf_we), 1);
            chk("R8 rf_idx", 32'(rf_idx), 32'(k + 1));
            chk("R8 rf_data", rf_data, 32'(100 + k));
            step();
        end
        chk("R6 drained", 32'(empty), 1);
        look(4'd3, 4'd8);
        chk("R7 released", 32'(lk_busy), 0);

        // R7 two writers of r2 (tags 0,1 after wrap)
        issue(2'd0, 16'd2, 1'b1, 3'd0, "R3 wrap");
        issue(2'd0, 16'd2, 1'b1, 3'd1, "R3 wrap");
        look(4'd2, 4'd2);
        chk("R5 youngest", 32'(lk_tag[0]), 1);
        beat(3'd0, 32'd7, 1'b0, 1'b0);
        chk("R8 idx r2", 32'(rf_idx), 2);
        chk("R8 data 7", rf_data, 7);
        step();
        chk("R7 younger keeps", 32'({lk_busy[0], 1'b0, lk_tag[0]}), 32'({1'b1, 1'b0, 3'd1}));
        beat(3'd1, 32'd8, 1'b0, 1'b0);
        chk("R8 data 8", rf_data, 8);
        step();
        chk("R7 cleared", 32'(lk_busy[0]), 0);

        // R8 store
        issue(2'd1, 16'h0040, 1'b1, 3'd2, "R8 store");
        beat(3'd2, 32'hBEEF, 1'b0, 1'b0);
        chk("R8 st_we", 32'({st_we, rf_we}), 32'(2'b10));
        chk("R8 st_addr", 32'(st_addr), 32'h40);
        chk("R8 st_data", st_data, 32'hBEEF);
        step();

        // R9 mispredicted branch flushes younger finished work
        issue(2'd2, 16'd0, 1'b1, 3'd3, "R9 branch");
        issue(2'd0, 16'd9, 1'b1, 3'd4, "R9 younger");
        beat(3'd4, 32'd44, 1'b0, 1'b0);
        beat(3'd3, 32'd0, 1'b0, 1'b1);
        chk("R9 redirect", 32'(redirect), 1);
        chk("R9 no write", 32'({rf_we, st_we}), 0);
        iss_valid = 1; iss_kind = 0; iss_dest = 16'd6;
        #1;
        chk("R3 no issue on flush", 32'(iss_ok), 0);
        step();
        iss_valid = 0;
        chk("R9 emptied", 32'(empty), 1);
        chk("R9 one cycle", 32'(redirect), 0);
        look(4'd9, 4'd6);
        chk("R9 table cleared", 32'(lk_busy), 0);

        // R10 fault on register write
        issue(2'd0, 16'd5, 1'b1, 3'd0, "R10 tag restarts");
        beat(3'd0, 32'd55, 1'b1, 1'b0);
        chk("R10 redirect", 32'(redirect), 1);
        chk("R10 no write", 32'(rf_we), 0);
        step();
        look(4'd5, 4'd5);
        chk("R10 table cleared", 32'(lk_busy[0]), 0);

        // R11 correctly predicted branch
        issue(2'd2, 16'd0, 1'b1, 3'd0, "R11 branch");
        beat(3'd0, 32'd1, 1'b0, 1'b0);
        chk("R11 silent", 32'({rf_we, st_we, redirect}), 0);
        step();
        chk("R11 retired", 32'(empty), 1);

        // R3 no reservation station
        iss_rs_free = 0;
        issue(2'd0, 16'd6, 1'b0, '0, "R3 rs busy");
        iss_rs_free = 1;
        chk("R3 still empty", 32'(empty), 1);

        // R12 beat into an unoccupied entry (tail is 1)
        beat(3'd1, 32'd9, 1'b0, 1'b0);
        issue(2'd0, 16'd6, 1'b1, 3'd1, "R12 alloc");
        look(4'd6, 4'd6);
        chk("R12 not ready", 32'({lk_busy[0], lk_ready[0]}), 32'(2'b10));
        chk("R12 no retire", 32'(rf_we), 0);
        beat(3'd1, 32'd66, 1'b0, 1'b0);
        chk("R12 later retire", rf_data, 66);
        step();

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule